// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous 256K x 8 static RAM. The host hands over one read or one write at a time through a request/ready handshake. The controller turns it into a pin sequence whose every phase lasts a whole number of clock cycles. Each phase length is derived at elaboration time from the clock period and the selected speed grade. Every nanosecond limit is rounded up to full cycles, and no phase is shorter than one cycle.

A read holds the address with the memory selected and its outputs enabled. It then samples the data bus on the last clock of the access window and returns the byte with a one-cycle valid strobe. A write runs in three phases: an address/select setup, a write-enable pulse and a recovery. The output enable stays inactive throughout, and the controller drives data for the whole sequence. All pins come from registers, so they change only at clock edges.

When no transfer is running, the memory is parked in standby and the controller's data driver is off. After a read, the controller waits out the time the memory may keep driving the bus before it takes any new request. This way the two sides never drive the bus at the same time.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high, `sram_ce_n`=1, `sram_ce`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0 and `rd_valid`=0. After reset, `sram_ce` is 1.
- R2: `ready` is high only in idle standby. A request is taken on a rising clock edge where `req` and `ready` are both high. A request held while `ready` is low has no effect on the pins.
- R3: A read drives `sram_addr` to the request address, with `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1. The byte on `sram_dq_in` at the final edge of the window appears on `rd_data` with `rd_valid` high for exactly one cycle.
- R4: The read window (cycles with `sram_oe_n` low) lasts max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles. The values are 85/85/45 ns for the slower grade (`FAST_GRADE`=0) and 70/70/35 ns for the faster grade. At 4 ns and the slower grade this gives 22 cycles, and `rd_valid` rises 22 cycles after acceptance.
- R5: During a write, `sram_oe_n` stays 1 and `sram_dq_oe` is 1 from acceptance until the end of recovery. `sram_dq_out` carries the request data and `sram_addr` the request address, both stable while `sram_we_n` is low.
- R6: The write phases last as follows. The pulse lasts WP = max(ceil(tWP 55 ns), ceil(tDS)) cycles, with tDS 35/30 ns. The setup lasts max(1, ceil(tCW) − WP) cycles, with tCW 70/60 ns. The recovery lasts max(1, ceil(tWC) − setup − WP) cycles, with tWC 85/70 ns. At 4 ns and the slower grade this gives 4, 14 and 4 cycles.
- R7: After a read ends, `ready` stays low for ceil(tHZ) cycles, with tHZ 35/25 ns (9 cycles at 4 ns, slower grade). `sram_dq_oe` never rises sooner than that after `sram_oe_n` goes high.
- R8: `sram_dq_oe`=1 never coincides with `sram_oe_n`=0, and `sram_we_n`=0 occurs only with `sram_ce_n`=0 and `sram_ce`=1.
- R9: After every transfer, the controller returns to standby with `sram_ce_n`=1, `sram_oe_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller can take a request |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Byte returned by a read |
| sram_addr | output | 18 | Memory address pins |
| sram_ce_n | output | 1 | Low-true chip select |
| sram_ce | output | 1 | High-true chip select |
| sram_oe_n | output | 1 | Low-true output enable |
| sram_we_n | output | 1 | Low-true write enable |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Enables the controller's data driver |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The bench drives a behavioural memory from the pins and runs random mixes of reads and writes over a small set of low address bytes. Reads therefore often return bytes written earlier, which separates correct address and data paths from swapped or stale ones. Directed sequences set up the corners in isolation:
- extreme addresses and data patterns (all-ones, all-zeros);
- back-to-back reads;
- write followed immediately by read;
- read followed immediately by write, which is the only case where the turnaround wait separates a safe bus handover from contention.

Each phase length is measured at the pins against counts the bench derives from the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_WSET  = 3'd2,
        PH_WPULS = 3'd3,
        PH_WREC  = 3'd4
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    typedef struct packed {
        int unsigned rc;
        int unsigned aa;
        int unsigned oe;
        int unsigned wc;
        int unsigned wp;
        int unsigned cw;
        int unsigned ds;
        int unsigned hz;
    } grade_ns_t;

    localparam pin_ctl_t PINS_STANDBY = '{ce_n: 1'b1, ce: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    localparam pin_ctl_t PINS_RESET   = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic grade_ns_t grade_ns(input bit fast);
        grade_ns_t g;
        if (fast) begin
            g = '{rc: 70, aa: 70, oe: 35, wc: 70, wp: 55, cw: 60, ds: 30, hz: 25};
        end else begin
            g = '{rc: 85, aa: 85, oe: 45, wc: 85, wp: 55, cw: 70, ds: 35, hz: 35};
        end
        return g;
    endfunction

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned rd_cycles(input bit fast, input int unsigned clk_ns);
        grade_ns_t g;
        g = grade_ns(fast);
        return imax(imax(ns_to_cyc(g.rc, clk_ns), ns_to_cyc(g.aa, clk_ns)), ns_to_cyc(g.oe, clk_ns));
    endfunction

    function automatic int unsigned wp_cycles(input bit fast, input int unsigned clk_ns);
        grade_ns_t g;
        g = grade_ns(fast);
        return imax(ns_to_cyc(g.wp, clk_ns), ns_to_cyc(g.ds, clk_ns));
    endfunction

    function automatic int unsigned su_cycles(input bit fast, input int unsigned clk_ns);
        grade_ns_t g;
        int unsigned cw;
        int unsigned wp;
        g  = grade_ns(fast);
        cw = ns_to_cyc(g.cw, clk_ns);
        wp = wp_cycles(fast, clk_ns);
        return (cw > wp + 1) ? (cw - wp) : 1;
    endfunction

    function automatic int unsigned rec_cycles(input bit fast, input int unsigned clk_ns);
        grade_ns_t g;
        int unsigned wc;
        int unsigned used;
        g    = grade_ns(fast);
        wc   = ns_to_cyc(g.wc, clk_ns);
        used = su_cycles(fast, clk_ns) + wp_cycles(fast, clk_ns);
        return (wc > used + 1) ? (wc - used) : 1;
    endfunction

    function automatic int unsigned turn_cycles(input bit fast, input int unsigned clk_ns);
        grade_ns_t g;
        g = grade_ns(fast);
        return ns_to_cyc(g.hz, clk_ns);
    endfunction

endpackage

// File: rtl/sram_down_counter.sv
module sram_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int CW     = 8,
    parameter int RD_C   = 22,
    parameter int SU_C   = 4,
    parameter int WP_C   = 14,
    parameter int RC_C   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              turn_ok,
    input  logic              ph_zero,
    output logic              ph_load,
    output logic [CW-1:0]     ph_val,
    output logic              turn_load,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] pin_addr,
    output pin_ctl_t          pin_ctl,
    output logic [DATA_W-1:0] pin_dq,
    input  logic [DATA_W-1:0] dq_in
);
    localparam logic [CW-1:0] RD_LD = CW'(RD_C - 1);
    localparam logic [CW-1:0] SU_LD = CW'(SU_C - 1);
    localparam logic [CW-1:0] WP_LD = CW'(WP_C - 1);
    localparam logic [CW-1:0] RC_LD = CW'(RC_C - 1);

    phase_e   ph_q;
    pin_ctl_t ctl_q;
    logic     accept;

    assign ready  = (ph_q == PH_IDLE) && turn_ok;
    assign accept = req && ready;

    always_comb begin
        ph_load   = 1'b0;
        ph_val    = '0;
        turn_load = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                ph_load = accept;
                ph_val  = req_we ? SU_LD : RD_LD;
            end
            PH_READ: begin
                turn_load = ph_zero;
            end
            PH_WSET: begin
                ph_load = ph_zero;
                ph_val  = WP_LD;
            end
            PH_WPULS: begin
                ph_load = ph_zero;
                ph_val  = RC_LD;
            end
            PH_WREC: begin
                ph_load = 1'b0;
            end
            default: begin
                ph_load = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            ctl_q    <= PINS_RESET;
            pin_addr <= '0;
            pin_dq   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            ctl_q.ce <= 1'b1;
            unique case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        pin_addr   <= req_addr;
                        ctl_q.ce_n <= 1'b0;
                        if (req_we) begin
                            pin_dq      <= req_wdata;
                            ctl_q.dq_oe <= 1'b1;
                            ph_q        <= PH_WSET;
                        end else begin
                            ctl_q.oe_n <= 1'b0;
                            ph_q       <= PH_READ;
                        end
                    end
                end
                PH_READ: begin
                    if (ph_zero) begin
                        rd_data    <= dq_in;
                        rd_valid   <= 1'b1;
                        ctl_q.oe_n <= 1'b1;
                        ctl_q.ce_n <= 1'b1;
                        ph_q       <= PH_IDLE;
                    end
                end
                PH_WSET: begin
                    if (ph_zero) begin
                        ctl_q.we_n <= 1'b0;
                        ph_q       <= PH_WPULS;
                    end
                end
                PH_WPULS: begin
                    if (ph_zero) begin
                        ctl_q.we_n <= 1'b1;
                        ph_q       <= PH_WREC;
                    end
                end
                PH_WREC: begin
                    if (ph_zero) begin
                        ctl_q.ce_n  <= 1'b1;
                        ctl_q.dq_oe <= 1'b0;
                        ph_q        <= PH_IDLE;
                    end
                end
                default: begin
                    ctl_q <= PINS_STANDBY;
                    ph_q  <= PH_IDLE;
                end
            endcase
        end
    end

    assign pin_ctl = ctl_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS     = 4,
    parameter bit          FAST_GRADE = 1'b0,
    parameter int          ADDR_W     = 18,
    parameter int          DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int RD_CYC   = int'(rd_cycles(FAST_GRADE, CLK_NS));
    localparam int SU_CYC   = int'(su_cycles(FAST_GRADE, CLK_NS));
    localparam int WP_CYC   = int'(wp_cycles(FAST_GRADE, CLK_NS));
    localparam int RC_CYC   = int'(rec_cycles(FAST_GRADE, CLK_NS));
    localparam int TURN_CYC = int'(turn_cycles(FAST_GRADE, CLK_NS));
    localparam int MAX_CYC  = int'(imax(imax(RD_CYC, TURN_CYC), imax(imax(SU_CYC, WP_CYC), RC_CYC)));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          ph_load;
    logic [CW-1:0] ph_val;
    logic          ph_zero;
    logic          turn_load;
    logic          turn_ok;
    pin_ctl_t      ctl;

    sram_down_counter #(.W(CW)) u_phase_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    sram_down_counter #(.W(CW)) u_turn_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (turn_load),
        .load_val (CW'(TURN_CYC)),
        .zero     (turn_ok)
    );

    sram_phase_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CW     (CW),
        .RD_C   (RD_CYC),
        .SU_C   (SU_CYC),
        .WP_C   (WP_CYC),
        .RC_C   (RC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .turn_ok   (turn_ok),
        .ph_zero   (ph_zero),
        .ph_load   (ph_load),
        .ph_val    (ph_val),
        .turn_load (turn_load),
        .ready     (ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pin_addr  (sram_addr),
        .pin_ctl   (ctl),
        .pin_dq    (sram_dq_out),
        .dq_in     (sram_dq_in)
    );

    assign sram_ce_n  = ctl.ce_n;
    assign sram_ce    = ctl.ce;
    assign sram_oe_n  = ctl.oe_n;
    assign sram_we_n  = ctl.we_n;
    assign sram_dq_oe = ctl.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS     = 4,
    parameter bit          FAST_GRADE = 1'b0,
    parameter int          ADDR_W     = 18,
    parameter int          DATA_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_ce,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    localparam int unsigned RD_N   = rd_cycles(FAST_GRADE, CLK_NS);
    localparam int unsigned WP_N   = wp_cycles(FAST_GRADE, CLK_NS);
    localparam int unsigned TURN_N = turn_cycles(FAST_GRADE, CLK_NS);

    logic [15:0] oe_low_run;
    logic [15:0] we_low_run;
    logic [15:0] oe_high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_low_run  <= '0;
            we_low_run  <= '0;
            oe_high_run <= '1;
        end else begin
            oe_low_run  <= !sram_oe_n ? oe_low_run + 1'b1 : '0;
            we_low_run  <= !sram_we_n ? we_low_run + 1'b1 : '0;
            if (!sram_oe_n) begin
                oe_high_run <= '0;
            end else if (oe_high_run != '1) begin
                oe_high_run <= oe_high_run + 1'b1;
            end
        end
    end

    // R1: strobe lines inactive while reset is held
    always @(posedge clk) begin
        if (rst) begin
            a_r1_reset_quiet: assert (!rd_valid || $past(!rst));
        end
    end

    a_r8_no_bus_fight: assert property (@(posedge clk) disable iff (rst)
        !(sram_dq_oe && !sram_oe_n));

    a_r8_we_with_ce: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_ce));

    a_r4_read_window: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (oe_low_run == 16'(RD_N)));

    a_r6_we_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_run == 16'(WP_N)));

    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> (oe_high_run >= 16'(TURN_N)));

    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r2_ready_in_standby: assert property (@(posedge clk) disable iff (rst)
        ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    a_r5_write_oe_high: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe));

    a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_dq_out) && $stable(sram_addr)));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .CLK_NS     (CLK_NS),
    .FAST_GRADE (FAST_GRADE),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ready       (ready),
    .rd_valid    (rd_valid),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_ce     (sram_ce),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out, sram_dq_in;

    always #2 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + 3) / 4;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(mx(cdiv(85), cdiv(85)), cdiv(45));
    localparam int E_WP   = mx(cdiv(55), cdiv(35));
    localparam int E_SU   = mx(1, cdiv(70) - E_WP);
    localparam int E_RC   = mx(1, cdiv(85) - E_SU - E_WP);
    localparam int E_TURN = cdiv(35);

    int n_tests = 0;
    int n_fail  = 0;
    int fight_seen = 0;
    bit finished = 1'b0;

    logic [7:0] model_mem [0:255];
    logic [7:0] exp_mem   [0:255];
    logic [17:0] cur_addr;
    logic [7:0]  cur_data;

    assign sram_dq_in = (!sram_ce_n && sram_ce && !sram_oe_n && sram_we_n) ? model_mem[sram_addr[7:0]] : 8'h5A;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pin monitor
    logic prev_oe_n = 1'b1, prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_dq_oe = 1'b0;
    int oe_low = 0, we_low = 0, ce_low = 0, oe_high = 1000;
    always @(negedge clk) begin
        if (!rst) begin
            if ((sram_dq_oe && !sram_oe_n) || (!sram_we_n && (sram_ce_n || !sram_ce))) fight_seen++;
            if (ready && !sram_ce_n) fight_seen++;
            if (!prev_oe_n && sram_oe_n) check(oe_low == E_RD, "R4 read window", oe_low, E_RD);
            if (prev_oe_n && !sram_oe_n)
                check(sram_addr == cur_addr && sram_we_n && !sram_ce_n, "R3 read pins addr",
                      int'(sram_addr), int'(cur_addr));
            if (prev_we_n && !sram_we_n) begin
                check(ce_low == E_SU, "R6 setup length", ce_low, E_SU);
                check(sram_dq_oe && sram_oe_n && sram_dq_out == cur_data && sram_addr == cur_addr,
                      "R5 write data", int'(sram_dq_out), int'(cur_data));
            end
            if (!prev_we_n && sram_we_n) begin
                check(we_low == E_WP, "R6 pulse length", we_low, E_WP);
                model_mem[sram_addr[7:0]] = sram_dq_out;
            end
            if (!prev_dq_oe && sram_dq_oe) check(oe_high >= E_TURN, "R7 driver turnaround", oe_high, E_TURN);
            oe_low  = !sram_oe_n ? oe_low + 1 : 0;
            we_low  = !sram_we_n ? we_low + 1 : 0;
            ce_low  = !sram_ce_n ? ce_low + 1 : 0;
            oe_high = !sram_oe_n ? 0 : oe_high + 1;
            prev_oe_n = sram_oe_n; prev_we_n = sram_we_n;
            prev_ce_n = sram_ce_n; prev_dq_oe = sram_dq_oe;
        end
    end

    task automatic run_op(input bit we, input logic [17:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        cur_addr = a; cur_data = d;
        @(negedge clk);
        req = 1'b0; req_wdata = ~d;
        n = 0;
        if (we) begin
            exp_mem[a[7:0]] = d;
            while (!ready) begin @(negedge clk); n++; end
            check(n == E_SU + E_WP + E_RC, "R6 write total", n, E_SU + E_WP + E_RC);
        end else begin
            while (!rd_valid) begin @(negedge clk); n++; end
            check(n == E_RD, "R4 read latency", n, E_RD);
            check(rd_data == exp_mem[a[7:0]], "R3 read data", int'(rd_data), int'(exp_mem[a[7:0]]));
            n = 0;
            while (!ready) begin @(negedge clk); n++; end
            check(n == E_TURN, "R7 ready gap", n, E_TURN);
            check(!rd_valid, "R3 valid one cycle", int'(rd_valid), 0);
        end
        check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R9 standby",
              int'({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}), 4'b1110);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) begin model_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sram_ce_n && !sram_ce && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid, "R1 reset pins",
              int'({sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid}), 6'b101100);
        rst = 1'b0;
        @(negedge clk);
        check(sram_ce && ready, "R1 R2 out of reset", int'({sram_ce, ready}), 2'b11);
        // directed corners
        run_op(1'b1, 18'h3FFFF, 8'hFF);
        run_op(1'b0, 18'h3FFFF, 8'h00);
        run_op(1'b1, 18'h00000, 8'h00);
        run_op(1'b0, 18'h00000, 8'h00);
        run_op(1'b0, 18'h3FFFF, 8'h00);
        run_op(1'b1, 18'h00010, 8'hA5);
        run_op(1'b0, 18'h00010, 8'h00);
        run_op(1'b1, 18'h00011, 8'h3C);
        // R2: request held during turnaround has no effect until ready
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 18'h00011;
        @(negedge clk);
        req = 1'b0;
        while (!rd_valid) @(negedge clk);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 18'h00012; req_wdata = 8'h77;
        @(negedge clk);
        check(sram_ce_n && !sram_dq_oe, "R2 held request ignored", int'(sram_dq_oe), 0);
        req = 1'b0;
        // random mix
        for (int i = 0; i < 70; i++) begin
            logic [31:0] r;
            r = $urandom;
            run_op(r[0], {r[31:22], 4'h0, r[7:4]}, r[15:8]);
        end
        check(fight_seen == 0, "R8 R2 no overlap", fight_seen, 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule